// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block gathers interrupt requests from internal sources and from external lines and holds one pending flag per source. External lines are brought into the processor clock domain through a two-flop synchronizer, and a rising edge on the synchronized line sets that source's flag. Internal requests set their flag in any cycle they are high. Source 0 is the illegal-instruction trap. It outranks every other source and can never be masked.

Arbitration happens only when the core signals that an instruction has completed. At that moment, each pending source's configured priority level is compared with the mask level taken from the status register. The winner among the allowed sources is latched. This is followed by a fixed two-cycle control sequence, which then presents a vector address to the fetch unit. The vector stays put until the core acknowledges it. The acknowledge clears only the winner's flag. Flags that were blocked stay set and compete again at the next boundary.

Top module: `irq_boundary_arbiter`

## Requirements
- R1: After reset, all pending flags are clear and vecValid is 0, so an instrDone strobe with no new request produces no vector.
- R2: Every source has its own pending flag. When several sources are pending, each boundary serves exactly one of them and the rest remain pending for later boundaries.
- R3: A rising edge on extReq[j] sets the flag of source NUM_INT+j within three clock edges. A line held high sets the flag only once, and it sets it again only after it falls and rises.
- R4: No arbitration happens unless instrDone is sampled high while the control sequence is idle. A pending request without that strobe never produces a vector.
- R5: A source whose level (2-bit field j of srcLevel, source j in bits 2j+1:2j) is below the top value is allowed only when its level is strictly greater than maskLevel. A blocked flag stays set and is served at a later boundary once allowed.
- R6: A source at the top level (3) is allowed whatever maskLevel holds.
- R7: Source 0 (intReq[0], the illegal-instruction trap) is allowed whatever maskLevel holds and wins over every other source, whatever its configured level.
- R8: Among allowed sources, the higher level wins. On equal levels, the lower source index wins. Internal requests intReq[i] are sources i, and extReq[j] is source NUM_INT+j.
- R9: The cycle after the edge that samples instrDone is control cycle 1, with vecValid still 0. vecValid rises at the next edge (control cycle 2).
- R10: vecAddr equals VEC_BASE plus twice the winning source index. It holds stable while vecValid is high until ack.
- R11: ack sampled while vecValid is high drops vecValid at the next edge and clears only the winner's flag. A request setting that same flag in the same cycle wins over the clear. instrDone during the control sequence is ignored, and so is ack while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| extReq | input | NUM_EXT | Raw external request lines, asynchronous |
| intReq | input | NUM_INT | Internal request lines; bit 0 is the illegal-instruction trap |
| srcLevel | input | NUM_SRC*LVL_W | Priority level per source, LVL_W bits each, source 0 in the low bits |
| maskLevel | input | LVL_W | Interrupt mask level from the status register |
| instrDone | input | 1 | Instruction-completion strobe from the core |
| ack | input | 1 | Core acknowledge of the presented vector |
| vecValid | output | 1 | Vector presented to the fetch unit |
| vecAddr | output | VEC_W | Vector address of the winning source |

## Verification
Two things can happen in the same cycle. The core's acknowledge can clear the winner's flag while that same source raises a fresh request. Also, an instrDone strobe can arrive while a vector is still being held. The bench drives ack together with a new request on the winning source, and it pulses instrDone during control cycle 2. It then expects no vector until the next real boundary, and at that boundary it expects the same source to win again. Randomized rounds mix levels, masks and request sets, and a bench model of the flags predicts each winner or the absence of a vector.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_ONE  = 2'd1,
    CTL_TWO  = 2'd2
  } ctlState_e;

  typedef struct packed {
    logic latchWin;  // capture the arbitration winner
    logic loadVec;   // build the vector address
    logic clrPend;   // clear the winner's pending flag
  } ctlStrobe_t;

endpackage

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instrDone,
  input  logic       anyAllowed,
  input  logic       ack,
  output ctlStrobe_t strobe,
  output logic       vecValid
);

  ctlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      CTL_IDLE: if (instrDone && anyAllowed) begin
        strobe.latchWin = 1'b1;
        stateNext       = CTL_ONE;
      end
      CTL_ONE: begin
        strobe.loadVec = 1'b1;
        stateNext      = CTL_TWO;
      end
      CTL_TWO: if (ack) begin
        strobe.clrPend = 1'b1;
        stateNext      = CTL_IDLE;
      end
      default: stateNext = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CTL_IDLE;
    else        state <= stateNext;
  end

  assign vecValid = (state == CTL_TWO);

  // R4: an idle sequencer stays idle without a boundary strobe
  assert_idle_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CTL_IDLE && !instrDone) |=> (state == CTL_IDLE));

  // R9: vector appears two edges after the boundary strobe
  assert_valid_after_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vecValid) |-> $past(instrDone, 2));

  // R11: acknowledge releases the vector
  assert_ack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && ack) |=> !vecValid);

endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int NUM_INT = 3,
  parameter int LVL_W   = 2,
  parameter int VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0040,
  localparam int NUM_SRC = NUM_EXT + NUM_INT,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EXT-1:0]       extReq,
  input  logic [NUM_INT-1:0]       intReq,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic [LVL_W-1:0]         maskLevel,
  input  ctlStrobe_t               strobe,
  output logic                     anyAllowed,
  output logic [VEC_W-1:0]         vecAddr
);

  localparam logic [LVL_W-1:0] MAX_LVL = '1;

  logic [NUM_EXT-1:0] extRise;
  logic [NUM_SRC-1:0] setVec, clrVec, pendFlags;
  logic [IDX_W-1:0]   bestIdx, winIdx;
  logic [LVL_W:0]     bestLvl;

  // Two-flop synchronizer and edge detector per external line
  for (genvar j = 0; j < NUM_EXT; j++) begin : g_sync
    logic meta, syncd, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta  <= 1'b0;
        syncd <= 1'b0;
        prev  <= 1'b0;
      end else begin
        meta  <= extReq[j];
        syncd <= meta;
        prev  <= syncd;
      end
    end
    assign extRise[j] = syncd && !prev;
  end

  assign setVec = {extRise, intReq};
  assign clrVec = strobe.clrPend ? (NUM_SRC'(1) << winIdx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendFlags <= '0;
    else        pendFlags <= (pendFlags & ~clrVec) | setVec;
  end

  // Mask compare and priority selection
  always_comb begin
    logic [LVL_W-1:0] lvl;
    logic [LVL_W:0]   eff;
    logic             ok;
    bestIdx    = '0;
    bestLvl    = '0;
    anyAllowed = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      lvl = srcLevel[i*LVL_W +: LVL_W];
      eff = (i == 0) ? {1'b1, {LVL_W{1'b0}}} : {1'b0, lvl};
      ok  = pendFlags[i] && ((i == 0) || (lvl == MAX_LVL) || (lvl > maskLevel));
      if (ok && (!anyAllowed || eff > bestLvl)) begin
        anyAllowed = 1'b1;
        bestLvl    = eff;
        bestIdx    = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winIdx  <= '0;
      vecAddr <= VEC_BASE;
    end else begin
      if (strobe.latchWin) winIdx  <= bestIdx;
      if (strobe.loadVec)  vecAddr <= VEC_BASE + (VEC_W'(winIdx) << 1);
    end
  end

  // R3: a detected set reaches its flag at the next edge
  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pendFlags & $past(setVec)) == $past(setVec)));

  // R5: flags never fall except on an acknowledge
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.clrPend |=> (($past(pendFlags) & ~pendFlags) == '0));

  // R2: an acknowledge drops only the winner's flag
  assert_clear_only_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrPend |=> (($past(pendFlags) & ~(NUM_SRC'(1) << $past(winIdx)) & ~pendFlags) == '0));

  // R7: a pending trap always takes the slot
  assert_trap_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.latchWin && pendFlags[0]) |=> (winIdx == '0));

endmodule

// File: rtl/irq_boundary_arbiter.sv
module irq_boundary_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int NUM_INT = 3,
  parameter int LVL_W   = 2,
  parameter int VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0040,
  localparam int NUM_SRC = NUM_EXT + NUM_INT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EXT-1:0]       extReq,
  input  logic [NUM_INT-1:0]       intReq,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic [LVL_W-1:0]         maskLevel,
  input  logic                     instrDone,
  input  logic                     ack,
  output logic                     vecValid,
  output logic [VEC_W-1:0]         vecAddr
);

  ctlStrobe_t strobe;
  logic       anyAllowed;

  irq_arb_control u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instrDone  (instrDone),
    .anyAllowed (anyAllowed),
    .ack        (ack),
    .strobe     (strobe),
    .vecValid   (vecValid)
  );

  irq_arb_datapath #(
    .NUM_EXT  (NUM_EXT),
    .NUM_INT  (NUM_INT),
    .LVL_W    (LVL_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .extReq     (extReq),
    .intReq     (intReq),
    .srcLevel   (srcLevel),
    .maskLevel  (maskLevel),
    .strobe     (strobe),
    .anyAllowed (anyAllowed),
    .vecAddr    (vecAddr)
  );

  // R10: vector held steady until acknowledged
  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !ack) |=> (vecValid && $stable(vecAddr)));

endmodule

// File: tb/irq_boundary_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_boundary_arbiter_tb_top;

  localparam int NE = 4;
  localparam int NI = 3;
  localparam int LW = 2;
  localparam int VW = 16;
  localparam int NS = NE + NI;
  localparam int BASE = 'h40;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NE-1:0] extReq = '0;
  logic [NI-1:0] intReq = '0;
  logic [NS*LW-1:0] srcLevel;
  logic [LW-1:0] maskLevel = '0;
  logic instrDone = 1'b0;
  logic ack = 1'b0;
  logic vecValid;
  logic [VW-1:0] vecAddr;

  logic [LW-1:0] lvl [NS];
  logic [NS-1:0] model = '0;
  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always_comb
    for (int s = 0; s < NS; s++) srcLevel[s*LW +: LW] = lvl[s];

  irq_boundary_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .extReq(extReq), .intReq(intReq),
    .srcLevel(srcLevel), .maskLevel(maskLevel), .instrDone(instrDone),
    .ack(ack), .vecValid(vecValid), .vecAddr(vecAddr)
  );

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int predict();
    int best = -1;
    int bestL = -1;
    for (int s = 0; s < NS; s++) begin
      int eff = (s == 0) ? 4 : int'(lvl[s]);
      bit ok = model[s] && (s == 0 || lvl[s] == 2'd3 || lvl[s] > maskLevel);
      if (ok && eff > bestL) begin
        best = s;
        bestL = eff;
      end
    end
    return best;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic injectInt(logic [NI-1:0] bits);
    @(negedge clk) intReq = bits;
    @(negedge clk) intReq = '0;
    model |= NS'(bits);
  endtask

  task automatic injectExt(logic [NE-1:0] bits);
    @(negedge clk) extReq = extReq | bits;
    tick(4);
    model |= NS'(bits) << NI;
  endtask

  task automatic boundary(string req);
    int w = predict();
    @(negedge clk) instrDone = 1'b1;
    @(negedge clk) instrDone = 1'b0;
    checkEq(req, "ctl cycle 1 vecValid", int'(vecValid), 0);
    @(negedge clk);
    if (w < 0) checkEq(req, "no vector", int'(vecValid), 0);
    else begin
      checkEq(req, "vecValid", int'(vecValid), 1);
      checkEq(req, "vecAddr", int'(vecAddr), BASE + 2 * w);
      ack = 1'b1;
      @(negedge clk) ack = 1'b0;
      checkEq(req, "released", int'(vecValid), 0);
      model[w] = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) lvl[s] = 2'd1;
    tick(3);
    checkEq("R1", "reset vecValid", int'(vecValid), 0);
    rst_n = 1'b1;
    tick(2);
    boundary("R1");

    // R4: pending without a boundary strobe stays quiet
    lvl[2] = 2'd2; maskLevel = 2'd0;
    injectInt(3'b100);
    tick(6);
    checkEq("R4", "no strobe no vector", int'(vecValid), 0);
    boundary("R4/R9/R10");

    // R5: blocked, then released by lowering the mask
    lvl[1] = 2'd1; maskLevel = 2'd1;
    injectInt(3'b010);
    boundary("R5 blocked");
    maskLevel = 2'd0;
    boundary("R5 released");

    // R6: top level ignores the mask
    lvl[4] = 2'd3; maskLevel = 2'd3;
    injectExt(4'b0010);
    boundary("R6");
    extReq = '0; tick(3);

    // R7: trap at level 0 beats a level-3 source under full mask
    lvl[0] = 2'd0; lvl[2] = 2'd3; maskLevel = 2'd3;
    injectInt(3'b101);
    boundary("R7");
    boundary("R7 next");
    maskLevel = 2'd0;

    // R8/R2: tie goes to the lower index, the other waits
    lvl[1] = 2'd2; lvl[5] = 2'd2; lvl[6] = 2'd1;
    injectInt(3'b010);
    injectExt(4'b1100);
    boundary("R8 tie");
    boundary("R2 second");
    boundary("R2 third");
    extReq = '0; tick(3);

    // R3: a held line sets its flag once
    injectExt(4'b0001);
    boundary("R3 first");
    tick(4);
    boundary("R3 held high");
    extReq = '0; tick(3);
    injectExt(4'b0001);
    boundary("R3 new rise");
    extReq = '0; tick(3);

    // R11: ack and a new request in the same cycle; strobe while busy
    lvl[1] = 2'd3; lvl[2] = 2'd1;
    injectInt(3'b110);
    @(negedge clk) instrDone = 1'b1;
    @(negedge clk) instrDone = 1'b0;
    @(negedge clk);
    checkEq("R11", "vecAddr src1", int'(vecAddr), BASE + 2);
    instrDone = 1'b1;
    @(negedge clk) instrDone = 1'b0;
    ack = 1'b1; intReq = 3'b010;
    @(negedge clk) ack = 1'b0; intReq = '0;
    checkEq("R11", "released", int'(vecValid), 0);
    tick(3);
    checkEq("R11", "busy strobe ignored", int'(vecValid), 0);
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    checkEq("R11", "idle ack ignored", int'(vecValid), 0);
    boundary("R11 re-pended");
    boundary("R11 remaining");

    // Random rounds
    for (int r = 0; r < 60; r++) begin
      logic [NI-1:0] ib;
      logic [NE-1:0] eb;
      for (int s = 0; s < NS; s++) lvl[s] = LW'($urandom_range(0, 3));
      maskLevel = LW'($urandom_range(0, 3));
      ib = NI'($urandom_range(0, 7)) & 3'b110;
      if ($urandom_range(0, 7) == 0) ib[0] = 1'b1;
      eb = NE'($urandom_range(0, 15));
      if (ib != '0) injectInt(ib);
      if (eb != '0) injectExt(eb);
      boundary("R8/R5 random");
      extReq = '0;
      tick(3);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule